// File: doc/BRIEF.md
# Bus-Master DMA Channel Control Registers

This block is the host-facing register set of a single bus-master DMA channel for an ATA disk interface. It stores a two-bit command byte (run and transfer direction), a status byte (channel busy, error, interrupt seen) and the physical base address of the descriptor table. The host reaches it through a 32-bit register port with per-byte lane enables, so any byte, half-word or word can be written or read in little-endian lane order.

The block drives the descriptor walker. It reloads the walker's table pointer on a run edge, starts a pending transfer when the channel was idle, and signals a halt when a stop takes effect. A stop requested while the data engine still reports work in flight is held back until that work drains. The drive interrupt is passed straight to the host, and its rising edge is captured in the status byte.

Two 32-bit words form the map. Word 0 (`reg_sel`=0) holds the command byte in lane 0 and the status byte in lane 2. Word 1 (`reg_sel`=1) holds the table base.

Top module: `bm_dma_regs`

## Requirements
- R1: A write to lane 0 of word 0 stores only bit 0 (run) and bit 3 (direction), so the command byte reads back as the written value AND 0x09. `run_start` and `xfer_dir` show the stored bits one cycle after the write.
- R2: A command write whose run bit equals the stored run bit updates the stored bits only. It produces no `walk_kick` and no `walk_reload`, and it does not change `chan_active`.
- R3: A command write that clears the run bit drops `chan_active` and pulses `walk_halt` on the next cycle when `xfer_busy` is low. When `xfer_busy` is high, both are held back until the cycle after `xfer_busy` goes low.
- R4: A command write that sets the run bit pulses `walk_reload` on the next cycle. If `chan_active` was low, it also sets `chan_active` and pulses `walk_kick`. If it was high (a stop still pending), there is no kick and the pending stop is cancelled.
- R5: Word 1 writes update only the lanes whose byte enable is set, with lane n taking `reg_wdata[8n+7:8n]`. Bits 1:0 of `tbl_base` are always zero.
- R6: Reads return the addressed word with every lane whose byte enable is clear forced to zero. Status is `{irq, err, active}` in bits 18:16.
- R7: `host_irq` follows `drv_irq`. A rising edge of `drv_irq` sets the status interrupt bit (bit 18). A falling edge leaves the status unchanged.
- R8: A `xfer_done` pulse while active leaves `chan_active` set if `xfer_more` is high and clears it if `xfer_more` is low.
- R9: Writing 1 to status bit 18 or bit 17 (lane 2 enabled) clears that bit, and writing 0 leaves it unchanged. Bit 16 (active) ignores writes.
- R10: A `xfer_err` pulse sets status bit 17.
- R11: Reset clears the command bits, the status bits, the table base, any pending stop and all control pulses.
- R12: A `restart_req` pulse produces a `walk_reload` pulse on the next cycle without changing `chan_active`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 1 | Word select: 0 control/status, 1 table base |
| reg_be | input | 4 | Byte-lane enables for reads and writes |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, lanes masked by `reg_be` |
| drv_irq | input | 1 | Interrupt level from the drive |
| host_irq | output | 1 | Interrupt level to the host |
| xfer_busy | input | 1 | Data engine has a transfer in flight |
| xfer_done | input | 1 | Data engine finished a transfer step |
| xfer_more | input | 1 | Qualifies `xfer_done`: more data pending |
| xfer_err | input | 1 | Data engine error pulse |
| restart_req | input | 1 | Request to rewind the walker to the table base |
| tbl_base | output | 32 | Descriptor table base address |
| run_start | output | 1 | Stored run bit |
| xfer_dir | output | 1 | Stored direction bit |
| chan_active | output | 1 | Channel active state |
| walk_kick | output | 1 | One-cycle pulse: begin a pending transfer |
| walk_reload | output | 1 | One-cycle pulse: reload walker pointer from base |
| walk_halt | output | 1 | One-cycle pulse: a stop has taken effect |

## Verification
The bench builds the block with its default parameters: a 32-bit port, a 32-bit pointer, two forced-zero low address bits and the combinational interrupt path. With these values every lane pattern of the table base is reachable, including single-byte, half-word and mixed enables. Lane 2 of word 0 can hold status while lane 0 holds command, which exercises W1C writes that do not disturb the run bit. The registered interrupt variant is not built by the bench.

// File: rtl/bm_dma_pkg.sv
package bm_dma_pkg;
   localparam int  CMD_RUN_BIT   = 0;
   localparam int  CMD_DIR_BIT   = 3;
   localparam int  CTRL_LANE     = 0;
   localparam int  STAT_LANE     = 2;
   localparam int  ST_ACT_BIT    = 0;
   localparam int  ST_ERR_BIT    = 1;
   localparam int  ST_IRQ_BIT    = 2;
   localparam logic SEL_CTRL     = 1'b0;
   localparam logic SEL_BASE     = 1'b1;

   typedef struct packed {
      logic irq;
      logic err;
      logic act;
   } bm_stat_t;

   function automatic logic [7:0] pack_cmd(input logic run, input logic dir);
      logic [7:0] b;
      b = '0;
      b[CMD_RUN_BIT] = run;
      b[CMD_DIR_BIT] = dir;
      return b;
   endfunction

   function automatic logic [7:0] pack_stat(input bm_stat_t s);
      logic [7:0] b;
      b = '0;
      b[ST_ACT_BIT] = s.act;
      b[ST_ERR_BIT] = s.err;
      b[ST_IRQ_BIT] = s.irq;
      return b;
   endfunction
endpackage

// File: rtl/bm_cmd_ctl.sv
module bm_cmd_ctl (
   input  logic clk,
   input  logic rst_n,
   input  logic cmd_we,
   input  logic w_run,
   input  logic w_dir,
   input  logic busy,
   input  logic done,
   input  logic more,
   input  logic restart,
   output logic run,
   output logic dir,
   output logic active,
   output logic kick,
   output logic reload,
   output logic halt
);
   logic stop_pend;
   logic run_edge;

   assign run_edge = cmd_we && (w_run != run);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run       <= 1'b0;
         dir       <= 1'b0;
         active    <= 1'b0;
         kick      <= 1'b0;
         reload    <= 1'b0;
         halt      <= 1'b0;
         stop_pend <= 1'b0;
      end else begin
         kick   <= 1'b0;
         halt   <= 1'b0;
         reload <= restart;
         if (run_edge) begin
            if (w_run) begin
               reload    <= 1'b1;
               stop_pend <= 1'b0;
               if (!active) begin
                  active <= 1'b1;
                  kick   <= 1'b1;
               end
            end else if (busy) begin
               stop_pend <= 1'b1;
            end else begin
               active <= 1'b0;
               halt   <= 1'b1;
            end
         end else if (stop_pend && !busy) begin
            stop_pend <= 1'b0;
            active    <= 1'b0;
            halt      <= 1'b1;
         end else if (done && active) begin
            active <= more;
         end
         if (cmd_we) begin
            run <= w_run;
            dir <= w_dir;
         end
      end
   end
endmodule

// File: rtl/bm_stat_flags.sv
module bm_stat_flags #(
   parameter bit IRQ_REG = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic drv_irq,
   input  logic err_evt,
   input  logic clr_we,
   input  logic clr_irq,
   input  logic clr_err,
   output logic irq_flag,
   output logic err_flag,
   output logic host_irq
);
   logic irq_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_q    <= 1'b0;
         irq_flag <= 1'b0;
         err_flag <= 1'b0;
      end else begin
         irq_q <= drv_irq;
         if (drv_irq && !irq_q)
            irq_flag <= 1'b1;
         else if (clr_we && clr_irq)
            irq_flag <= 1'b0;
         if (err_evt)
            err_flag <= 1'b1;
         else if (clr_we && clr_err)
            err_flag <= 1'b0;
      end
   end

   generate
      if (IRQ_REG) begin : g_irq_reg
         assign host_irq = irq_q;
      end else begin : g_irq_comb
         assign host_irq = drv_irq;
      end
   endgenerate
endmodule

// File: rtl/bm_base_reg.sv
module bm_base_reg #(
   parameter int BUS_W     = 32,
   parameter int PTR_W     = 32,
   parameter int ALIGN_LSB = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               we,
   input  logic [BUS_W/8-1:0] be,
   input  logic [BUS_W-1:0]   wdata,
   output logic [PTR_W-1:0]   base
);
   localparam int PLANES = PTR_W / 8;

   logic [PTR_W-1:0] base_q;

   generate
      for (genvar l = 0; l < PLANES; l++) begin : g_lane
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               base_q[8*l +: 8] <= '0;
            else if (we && be[l])
               base_q[8*l +: 8] <= wdata[8*l +: 8];
         end
      end
   endgenerate

   assign base = {base_q[PTR_W-1:ALIGN_LSB], {ALIGN_LSB{1'b0}}};
endmodule

// File: rtl/bm_dma_regs.sv
module bm_dma_regs #(
   parameter int BUS_W     = 32,
   parameter int PTR_W     = 32,
   parameter int ALIGN_LSB = 2,
   parameter bit IRQ_REG   = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               reg_sel,
   input  logic [BUS_W/8-1:0] reg_be,
   input  logic               reg_we,
   input  logic [BUS_W-1:0]   reg_wdata,
   output logic [BUS_W-1:0]   reg_rdata,
   input  logic               drv_irq,
   output logic               host_irq,
   input  logic               xfer_busy,
   input  logic               xfer_done,
   input  logic               xfer_more,
   input  logic               xfer_err,
   input  logic               restart_req,
   output logic [PTR_W-1:0]   tbl_base,
   output logic               run_start,
   output logic               xfer_dir,
   output logic               chan_active,
   output logic               walk_kick,
   output logic               walk_reload,
   output logic               walk_halt
);
   import bm_dma_pkg::*;

   localparam int LANES = BUS_W / 8;

   generate
      if (BUS_W % 8 != 0 || BUS_W < 32)
         $error("bm_dma_regs: BUS_W must be a multiple of 8 and at least 32");
      if (PTR_W % 8 != 0 || PTR_W > BUS_W)
         $error("bm_dma_regs: PTR_W must be whole bytes and fit the bus");
      if (ALIGN_LSB < 1 || ALIGN_LSB >= 8)
         $error("bm_dma_regs: ALIGN_LSB out of range");
   endgenerate

   logic     ctrl_we, stat_we, base_we;
   logic     irq_flag, err_flag;
   bm_stat_t stat;
   logic [BUS_W-1:0] word_ctrl, word_base, word_sel, lane_mask;

   assign ctrl_we = reg_we && (reg_sel == SEL_CTRL) && reg_be[CTRL_LANE];
   assign stat_we = reg_we && (reg_sel == SEL_CTRL) && reg_be[STAT_LANE];
   assign base_we = reg_we && (reg_sel == SEL_BASE);

   bm_cmd_ctl u_cmd (
      .clk     (clk),
      .rst_n   (rst_n),
      .cmd_we  (ctrl_we),
      .w_run   (reg_wdata[8*CTRL_LANE + CMD_RUN_BIT]),
      .w_dir   (reg_wdata[8*CTRL_LANE + CMD_DIR_BIT]),
      .busy    (xfer_busy),
      .done    (xfer_done),
      .more    (xfer_more),
      .restart (restart_req),
      .run     (run_start),
      .dir     (xfer_dir),
      .active  (chan_active),
      .kick    (walk_kick),
      .reload  (walk_reload),
      .halt    (walk_halt)
   );

   bm_stat_flags #(.IRQ_REG(IRQ_REG)) u_stat (
      .clk      (clk),
      .rst_n    (rst_n),
      .drv_irq  (drv_irq),
      .err_evt  (xfer_err),
      .clr_we   (stat_we),
      .clr_irq  (reg_wdata[8*STAT_LANE + ST_IRQ_BIT]),
      .clr_err  (reg_wdata[8*STAT_LANE + ST_ERR_BIT]),
      .irq_flag (irq_flag),
      .err_flag (err_flag),
      .host_irq (host_irq)
   );

   bm_base_reg #(.BUS_W(BUS_W), .PTR_W(PTR_W), .ALIGN_LSB(ALIGN_LSB)) u_base (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (base_we),
      .be    (reg_be),
      .wdata (reg_wdata),
      .base  (tbl_base)
   );

   assign stat = '{irq: irq_flag, err: err_flag, act: chan_active};

   always_comb begin
      word_ctrl = '0;
      word_ctrl[8*CTRL_LANE +: 8] = pack_cmd(run_start, xfer_dir);
      word_ctrl[8*STAT_LANE +: 8] = pack_stat(stat);
   end

   assign word_base = BUS_W'(tbl_base);
   assign word_sel  = (reg_sel == SEL_BASE) ? word_base : word_ctrl;

   generate
      for (genvar l = 0; l < LANES; l++) begin : g_rmask
         assign lane_mask[8*l +: 8] = {8{reg_be[l]}};
      end
   endgenerate

   assign reg_rdata = word_sel & lane_mask;
endmodule

// File: rtl/bm_dma_regs_chk.sv
module bm_dma_regs_chk (
   input logic clk,
   input logic rst_n,
   input logic ctrl_wr,
   input logic wrun,
   input logic run_start,
   input logic chan_active,
   input logic walk_kick,
   input logic walk_halt,
   input logic xfer_busy,
   input logic drv_irq,
   input logic irq_flag
);
   // R2: equal run bit never kicks the walker
   p_same_run_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_wr && (wrun == run_start)) |=> !walk_kick);

   // R3: a halt leaves the channel inactive
   p_halt_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
      walk_halt |-> !chan_active);

   // R3: a halt only follows a cycle with nothing in flight
   p_halt_drained_r3: assert property (@(posedge clk) disable iff (!rst_n)
      walk_halt |-> !$past(xfer_busy));

   // R4: a kick comes only from an idle channel and makes it active
   p_kick_from_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
      walk_kick |-> (chan_active && !$past(chan_active)));

   // R4: the channel turns active only together with a kick
   p_active_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(chan_active) |-> walk_kick);

   // R7: a rising drive interrupt is recorded
   p_irq_capture_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(drv_irq) |=> irq_flag);
endmodule

bind bm_dma_regs bm_dma_regs_chk i_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .ctrl_wr     (ctrl_we),
   .wrun        (reg_wdata[0]),
   .run_start   (run_start),
   .chan_active (chan_active),
   .walk_kick   (walk_kick),
   .walk_halt   (walk_halt),
   .xfer_busy   (xfer_busy),
   .drv_irq     (drv_irq),
   .irq_flag    (irq_flag)
);

// File: tb/test_bm_dma_regs.sv
module test_bm_dma_regs;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_sel = 1'b0;
   logic [3:0]  reg_be = 4'h0;
   logic        reg_we = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        drv_irq = 1'b0, host_irq;
   logic        xfer_busy = 1'b0, xfer_done = 1'b0, xfer_more = 1'b0;
   logic        xfer_err = 1'b0, restart_req = 1'b0;
   logic [31:0] tbl_base;
   logic        run_start, xfer_dir, chan_active, walk_kick, walk_reload, walk_halt;

   int n_chk = 0;
   int n_err = 0;
   bit finished = 0;

   // reference model state
   bit m_run, m_dir, m_act, m_pend, m_kick, m_load, m_halt, m_irq, m_err, m_prev;
   bit [31:0] m_base;

   always #2.5 clk = ~clk;

   bm_dma_regs i_bm_dma_regs (
      .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_be(reg_be), .reg_we(reg_we),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .drv_irq(drv_irq), .host_irq(host_irq),
      .xfer_busy(xfer_busy), .xfer_done(xfer_done), .xfer_more(xfer_more),
      .xfer_err(xfer_err), .restart_req(restart_req), .tbl_base(tbl_base),
      .run_start(run_start), .xfer_dir(xfer_dir), .chan_active(chan_active),
      .walk_kick(walk_kick), .walk_reload(walk_reload), .walk_halt(walk_halt)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic model_step();
      bit cw, sw;
      if (!rst_n) begin
         {m_run, m_dir, m_act, m_pend, m_kick, m_load, m_halt, m_irq, m_err, m_prev} = '0;
         m_base = '0;
         return;
      end
      cw = reg_we && !reg_sel && reg_be[0];
      sw = reg_we && !reg_sel && reg_be[2];
      m_kick = 0; m_halt = 0; m_load = restart_req;
      if (cw && (reg_wdata[0] != m_run)) begin
         if (reg_wdata[0]) begin
            m_load = 1; m_pend = 0;
            if (!m_act) begin m_act = 1; m_kick = 1; end
         end else if (xfer_busy) m_pend = 1;
         else begin m_act = 0; m_halt = 1; end
      end else if (m_pend && !xfer_busy) begin
         m_pend = 0; m_act = 0; m_halt = 1;
      end else if (xfer_done && m_act) m_act = xfer_more;
      if (cw) begin m_run = reg_wdata[0]; m_dir = reg_wdata[3]; end
      if (sw && reg_wdata[18]) m_irq = 0;
      if (sw && reg_wdata[17]) m_err = 0;
      if (drv_irq && !m_prev) m_irq = 1;
      if (xfer_err) m_err = 1;
      m_prev = drv_irq;
      if (reg_we && reg_sel)
         for (int l = 0; l < 4; l++)
            if (reg_be[l]) m_base[8*l +: 8] = reg_wdata[8*l +: 8];
      m_base[1:0] = 2'b00;
   endtask

   function automatic bit [31:0] model_rdata();
      bit [31:0] w;
      if (reg_sel) w = m_base;
      else w = {13'b0, m_irq, m_err, m_act, 12'b0, m_dir, 2'b0, m_run};
      for (int l = 0; l < 4; l++)
         if (!reg_be[l]) w[8*l +: 8] = 8'h00;
      return w;
   endfunction

   task automatic compare_all();
      chk("R1 run_start", run_start, m_run);
      chk("R1 xfer_dir", xfer_dir, m_dir);
      chk("R4 chan_active", chan_active, m_act);
      chk("R4 walk_kick", walk_kick, m_kick);
      chk("R12 walk_reload", walk_reload, m_load);
      chk("R3 walk_halt", walk_halt, m_halt);
      chk("R5 tbl_base", tbl_base, m_base);
      chk("R7 host_irq", host_irq, drv_irq);
      chk("R6 reg_rdata", reg_rdata, model_rdata());
   endtask

   task automatic cycle();
      @(posedge clk);
      model_step();
      @(negedge clk);
      compare_all();
   endtask

   task automatic wr(input logic sel, input logic [3:0] be, input logic [31:0] d);
      reg_sel = sel; reg_be = be; reg_wdata = d; reg_we = 1'b1;
      cycle();
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic sel, input logic [3:0] be);
      reg_sel = sel; reg_be = be;
      #0.1;
   endtask

   initial begin
      @(negedge clk);
      repeat (3) cycle();
      // R11: reset state
      chk("R11 reset active", chan_active, 0);
      chk("R11 reset base", tbl_base, 0);
      rst_n = 1'b1;
      cycle();

      // R1 / R4: run edge from idle
      wr(0, 4'b0001, 32'h0000_00FF);
      chk("R4 kick on run edge", walk_kick, 1);
      chk("R4 reload on run edge", walk_reload, 1);
      chk("R4 active set", chan_active, 1);
      chk("R1 cmd masked readback", reg_rdata, 32'h0000_0009);
      cycle();

      // R2: same run bit, direction cleared
      wr(0, 4'b0001, 32'h0000_0001);
      chk("R2 no kick", walk_kick, 0);
      chk("R2 no reload", walk_reload, 0);
      chk("R2 active kept", chan_active, 1);
      chk("R1 dir cleared", xfer_dir, 0);

      // R8: done with more, then done without
      xfer_done = 1; xfer_more = 1; cycle();
      chk("R8 more keeps active", chan_active, 1);
      xfer_more = 0; cycle();
      chk("R8 last clears active", chan_active, 0);
      xfer_done = 0; cycle();

      // R3: stop while idle engine
      wr(0, 4'b0001, 32'h0);
      chk("R3 halt immediate", walk_halt, 1);
      wr(0, 4'b0001, 32'h1);
      chk("R4 kick again", walk_kick, 1);

      // R3: stop while busy waits for drain
      xfer_busy = 1;
      wr(0, 4'b0001, 32'h0);
      chk("R3 no halt while busy", walk_halt, 0);
      chk("R3 active while busy", chan_active, 1);
      cycle(); cycle();
      chk("R3 still active", chan_active, 1);
      xfer_busy = 0; cycle();
      chk("R3 halt after drain", walk_halt, 1);
      chk("R3 inactive after drain", chan_active, 0);
      cycle();

      // R4: run edge while a stop is pending
      wr(0, 4'b0001, 32'h1);
      xfer_busy = 1;
      wr(0, 4'b0001, 32'h0);
      wr(0, 4'b0001, 32'h9);
      chk("R4 reload while active", walk_reload, 1);
      chk("R4 no kick while active", walk_kick, 0);
      xfer_busy = 0; cycle();
      chk("R4 pending stop cancelled", walk_halt, 0);
      chk("R4 remains active", chan_active, 1);

      // R12: restart
      restart_req = 1; cycle(); restart_req = 0;
      chk("R12 reload pulse", walk_reload, 1);
      chk("R12 active unchanged", chan_active, 1);
      cycle();

      // R5 / R6: table base lanes
      wr(1, 4'b1111, 32'hDEAD_BEEF);
      chk("R5 aligned base", tbl_base, 32'hDEAD_BEEC);
      rd(1, 4'b0100);
      chk("R6 lane 2 read", reg_rdata, 32'h00AD_0000);
      wr(1, 4'b0001, 32'h0000_0077);
      chk("R5 byte write", tbl_base, 32'hDEAD_BE74);
      wr(1, 4'b1100, 32'h1234_0000);
      chk("R5 half write", tbl_base, 32'h1234_BE74);
      wr(1, 4'b0010, 32'h0000_5500);
      chk("R5 lane 1 write", tbl_base, 32'h1234_5574);
      rd(1, 4'b0011);
      chk("R6 low half read", reg_rdata, 32'h0000_5574);

      // R7: interrupt capture and pass-through
      rd(0, 4'b0100);
      drv_irq = 1; #0.1;
      chk("R7 host follows rise", host_irq, 1);
      cycle();
      chk("R7 irq bit set", reg_rdata[18], 1);
      drv_irq = 0; #0.1;
      chk("R7 host follows fall", host_irq, 0);
      cycle();
      chk("R7 irq bit held", reg_rdata[18], 1);

      // R9: W1C, zero writes ignored, active read-only
      wr(0, 4'b0100, 32'h0000_0000);
      chk("R9 zero write keeps irq", reg_rdata[18], 1);
      wr(0, 4'b0100, 32'h0007_0000);
      chk("R9 irq cleared", reg_rdata[18], 0);
      chk("R9 active unaffected", chan_active, 1);
      chk("R9 run unaffected", run_start, 1);

      // R10: error capture then clear
      xfer_err = 1; cycle(); xfer_err = 0;
      chk("R10 err set", reg_rdata[17], 1);
      wr(0, 4'b0100, 32'h0002_0000);
      chk("R9 err cleared", reg_rdata[17], 0);

      // R11: reset in mid activity
      drv_irq = 1; cycle();
      rst_n = 0; cycle(); cycle();
      chk("R11 run cleared", run_start, 0);
      chk("R11 active cleared", chan_active, 0);
      chk("R11 base cleared", tbl_base, 0);
      chk("R11 status cleared", reg_rdata, 0);
      drv_irq = 0; rst_n = 1; cycle(); cycle();

      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_err++;
         $display("FAIL watchdog R11 actual=hung expected=done");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end
endmodule